// File: doc/BRIEF.md
# Strip Pedestal, Common-Mode and Threshold Chain

This block conditions the digitized amplitudes of a group of silicon strips and reduces each strip to a single hit bit. Samples enter one per cycle at most, serially in strip order, each with a valid strobe. A per-strip baseline is removed first, clamped at zero. The mean of the baseline-corrected values over the whole group is then removed from every strip, again clamped at zero. Last, each corrected value is compared against a per-strip limit.

The group mean is known only after the final strip has arrived. The corrected values are therefore held in a buffer sized to the group. Once the group is complete, the hit bits are streamed out one per cycle with their strip index. The next group may start arriving in the cycle right after the previous group's last sample. Reading of the old contents always stays ahead of writing of the new ones.

Baseline and limit tables are written through an address/data/write-enable port. Writes go to shadow copies. These are committed only at a group boundary, so a group always sees one consistent calibration.

Top module: `strip_cond_chain`

## Requirements
- R1: After reset, `hit_valid` is low and stays low until a complete group of GROUP_N accepted samples has arrived.
- R2: The baseline-corrected value of a strip is `sample - baseline` when the sample exceeds the baseline, and 0 otherwise. It never wraps.
- R3: The group offset is floor(sum of the GROUP_N baseline-corrected values / GROUP_N). Each strip's corrected value is its baseline-corrected value minus that offset, clamped at 0.
- R4: `hit` for a strip is 1 only when its corrected value is strictly greater than that strip's limit. Equality gives 0.
- R5: The group's last sample is accepted at clock edge E. Then `hit_valid` rises after edge E+1 and stays high for exactly GROUP_N consecutive cycles. During that run, `hit_idx` counts 0, 1, ... GROUP_N-1.
- R6: Cycles with `s_valid` low are ignored. Their `s_data` has no effect, and the strip position advances only on accepted samples.
- R7: `cfg_we` writes `cfg_data` into the baseline table when `cfg_tbl`=0 and into the limit table when `cfg_tbl`=1, at strip `cfg_addr`. A write made while a group is partly received has no effect on that group. It applies from the next group on, for both tables.
- R8: A new group may begin in the cycle after the previous group's last sample. The previous group's hit bits are unaffected.
- R9: After reset, both tables hold 0 in every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | SAMPLE_W | Strip amplitude, strips in order 0..GROUP_N-1 |
| cfg_we | input | 1 | Calibration write enable |
| cfg_tbl | input | 1 | Table select: 0 baseline, 1 limit |
| cfg_addr | input | log2(GROUP_N) | Strip index for the write |
| cfg_data | input | SAMPLE_W | Calibration value |
| hit_valid | output | 1 | Hit bit strobe |
| hit | output | 1 | Hit flag for strip `hit_idx` |
| hit_idx | output | log2(GROUP_N) | Strip index of the hit bit |

## Verification
The assertions check the cycle-level invariants on every cycle. The output index steps by one within a run and a run always starts at strip 0. The baseline-corrected value never exceeds the raw sample, and the offset-corrected value never exceeds the buffered one. The strip position holds while no sample is offered. Only the bench's scenarios can show the arithmetic results and the strict comparison at equality. The same holds for the exact latency to the first hit bit, the deferral of calibration writes made mid-group, and back-to-back groups that leave the earlier group's results intact.

// File: rtl/strip_cond_pkg.sv
package strip_cond_pkg;
   typedef enum logic {
      CAL_BASE  = 1'b0,
      CAL_LIMIT = 1'b1
   } cal_tbl_e;
endpackage

// File: rtl/strip_cal_bank.sv
// Calibration table with shadow and active copies. The optional lagged copy
// follows the active copy by one group for use in the emission phase.
module strip_cal_bank #(
   parameter int W      = 8,
   parameter int N      = 64,
   parameter bit LAGGED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [$clog2(N)-1:0] wr_addr,
   input  logic [W-1:0]         wr_data,
   input  logic                 commit_idle,
   input  logic                 commit_grp,
   input  logic [$clog2(N)-1:0] rd_addr,
   output logic [W-1:0]         rd_data
);
   logic [W-1:0] shadow [N];
   logic [W-1:0] active [N];
   logic         commit;

   assign commit = commit_idle | commit_grp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            shadow[i] <= '0;
            active[i] <= '0;
         end
      end else begin
         if (wr_en) shadow[wr_addr] <= wr_data;
         if (commit) begin
            for (int i = 0; i < N; i++) active[i] <= shadow[i];
         end
      end
   end

   generate
      if (LAGGED) begin : g_lag
         logic [W-1:0] lagged [N];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N; i++) lagged[i] <= '0;
            end else if (commit_grp) begin
               for (int i = 0; i < N; i++) lagged[i] <= active[i];
            end
         end
         assign rd_data = lagged[rd_addr];
      end else begin : g_direct
         assign rd_data = active[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/strip_ped_accum.sv
// Baseline removal, holding buffer and group-sum accumulation.
module strip_ped_accum #(
   parameter int W = 8,
   parameter int N = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s_valid,
   input  logic [W-1:0]         s_data,
   input  logic [W-1:0]         base,
   output logic [$clog2(N)-1:0] idx,
   output logic                 grp_done,
   output logic [W-1:0]         sub,
   output logic [W-1:0]         cm,
   input  logic [$clog2(N)-1:0] rd_addr,
   output logic [W-1:0]         rd_data
);
   localparam int SHIFT = $clog2(N);
   localparam int SUM_W = W + SHIFT;
   localparam logic [SHIFT-1:0] LAST = SHIFT'(N - 1);

   logic [W-1:0]     hold [N];
   logic [SUM_W-1:0] acc;
   logic [SUM_W-1:0] sum_next;

   assign sub      = (s_data > base) ? (s_data - base) : '0;
   assign sum_next = acc + SUM_W'(sub);
   assign grp_done = s_valid && (idx == LAST);
   assign rd_data  = hold[rd_addr];

   always_ff @(posedge clk) begin
      if (s_valid) hold[idx] <= sub;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         acc <= '0;
         cm  <= '0;
      end else if (s_valid) begin
         if (idx == LAST) begin
            idx <= '0;
            acc <= '0;
            cm  <= W'(sum_next >> SHIFT);
         end else begin
            idx <= idx + 1'b1;
            acc <= sum_next;
         end
      end
   end
endmodule

// File: rtl/strip_hit_emit.sv
// Walks the holding buffer after a group completes, removes the group offset
// and compares against the lagged limit table.
module strip_hit_emit #(
   parameter int W = 8,
   parameter int N = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [W-1:0]         raw,
   input  logic [W-1:0]         cm,
   input  logic [W-1:0]         limit,
   output logic [$clog2(N)-1:0] rd_addr,
   output logic                 busy,
   output logic [W-1:0]         corr,
   output logic                 hit_valid,
   output logic                 hit,
   output logic [$clog2(N)-1:0] hit_idx
);
   localparam int AW = $clog2(N);
   localparam logic [AW-1:0] LAST = AW'(N - 1);

   logic [AW-1:0] ptr;

   assign rd_addr = ptr;
   assign corr    = (raw > cm) ? (raw - cm) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         ptr  <= '0;
      end else if (busy) begin
         ptr <= ptr + 1'b1;
         if (ptr == LAST) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_valid <= 1'b0;
         hit       <= 1'b0;
         hit_idx   <= '0;
      end else begin
         hit_valid <= busy;
         hit       <= busy && (corr > limit);
         hit_idx   <= busy ? ptr : '0;
      end
   end
endmodule

// File: rtl/strip_cond_chain.sv
module strip_cond_chain #(
   parameter int SAMPLE_W = 8,
   parameter int GROUP_N  = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       s_valid,
   input  logic [SAMPLE_W-1:0]        s_data,
   input  logic                       cfg_we,
   input  logic                       cfg_tbl,
   input  logic [$clog2(GROUP_N)-1:0] cfg_addr,
   input  logic [SAMPLE_W-1:0]        cfg_data,
   output logic                       hit_valid,
   output logic                       hit,
   output logic [$clog2(GROUP_N)-1:0] hit_idx
);
   import strip_cond_pkg::*;

   localparam int AW = $clog2(GROUP_N);

   generate
      if (GROUP_N < 2 || (1 << AW) != GROUP_N) begin : g_bad_group
         $error("GROUP_N must be a power of two and at least 2");
      end
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("SAMPLE_W must be at least 2");
      end
   endgenerate

   cal_tbl_e              tbl_sel;
   logic                  we_base, we_limit;
   logic [AW-1:0]         in_idx;
   logic                  grp_done;
   logic                  idle_edge;
   logic [SAMPLE_W-1:0]   base_v, limit_v, in_sub, cm_v, em_raw, em_corr;
   logic [AW-1:0]         em_addr;
   logic                  em_busy;

   assign tbl_sel   = cal_tbl_e'(cfg_tbl);
   assign we_base   = cfg_we && (tbl_sel == CAL_BASE);
   assign we_limit  = cfg_we && (tbl_sel == CAL_LIMIT);
   assign idle_edge = !s_valid && (in_idx == '0);

   strip_cal_bank #(.W(SAMPLE_W), .N(GROUP_N), .LAGGED(1'b0)) u_base (
      .clk(clk), .rst_n(rst_n),
      .wr_en(we_base), .wr_addr(cfg_addr), .wr_data(cfg_data),
      .commit_idle(idle_edge), .commit_grp(grp_done),
      .rd_addr(in_idx), .rd_data(base_v)
   );

   strip_cal_bank #(.W(SAMPLE_W), .N(GROUP_N), .LAGGED(1'b1)) u_limit (
      .clk(clk), .rst_n(rst_n),
      .wr_en(we_limit), .wr_addr(cfg_addr), .wr_data(cfg_data),
      .commit_idle(idle_edge), .commit_grp(grp_done),
      .rd_addr(em_addr), .rd_data(limit_v)
   );

   strip_ped_accum #(.W(SAMPLE_W), .N(GROUP_N)) u_accum (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_data(s_data), .base(base_v),
      .idx(in_idx), .grp_done(grp_done), .sub(in_sub), .cm(cm_v),
      .rd_addr(em_addr), .rd_data(em_raw)
   );

   strip_hit_emit #(.W(SAMPLE_W), .N(GROUP_N)) u_emit (
      .clk(clk), .rst_n(rst_n),
      .start(grp_done), .raw(em_raw), .cm(cm_v), .limit(limit_v),
      .rd_addr(em_addr), .busy(em_busy), .corr(em_corr),
      .hit_valid(hit_valid), .hit(hit), .hit_idx(hit_idx)
   );
endmodule

// File: rtl/strip_cond_chk.sv
module strip_cond_chk #(
   parameter int W = 8,
   parameter int N = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 s_valid,
   input logic [W-1:0]         s_data,
   input logic [$clog2(N)-1:0] in_idx,
   input logic [W-1:0]         in_sub,
   input logic                 em_busy,
   input logic [W-1:0]         em_raw,
   input logic [W-1:0]         em_corr,
   input logic                 hit_valid,
   input logic [$clog2(N)-1:0] hit_idx
);
   localparam int AW = $clog2(N);
   localparam logic [AW-1:0] LAST = AW'(N - 1);

   // R5: indices within a run step by one
   a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && hit_idx != LAST) |=> (hit_valid && (hit_idx - $past(hit_idx)) == AW'(1)));

   // R5: every run begins at strip 0
   a_r5_run_start: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |=> (!hit_valid || hit_idx == '0));

   // R2: baseline removal never exceeds the raw sample
   a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |-> (in_sub <= s_data));

   // R3: offset removal never exceeds the buffered value
   a_r3_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      em_busy |-> (em_corr <= em_raw));

   // R6: strip position holds on idle cycles
   a_r6_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> (in_idx == $past(in_idx)));
endmodule

bind strip_cond_chain strip_cond_chk #(.W(SAMPLE_W), .N(GROUP_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
   .in_idx(in_idx), .in_sub(in_sub), .em_busy(em_busy),
   .em_raw(em_raw), .em_corr(em_corr),
   .hit_valid(hit_valid), .hit_idx(hit_idx)
);

// File: tb/sim_strip_cond_chain.sv
module sim_strip_cond_chain;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 64;
   localparam int AW = 6;

   typedef struct packed {
      logic [7:0] seed;
      logic [7:0] pk;
      logic [7:0] tk;
      logic       gap;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{8'd3,   8'd10, 8'd5,  1'b0},
      '{8'd17,  8'd40, 8'd30, 1'b0},
      '{8'd101, 8'd0,  8'd60, 1'b1},
      '{8'd77,  8'd90, 8'd12, 1'b0},
      '{8'd200, 8'd25, 8'd0,  1'b1}
   };

   logic clk = 0;
   logic rst_n = 0;
   logic s_valid = 0;
   logic [7:0] s_data = 0;
   logic cfg_we = 0;
   logic cfg_tbl = 0;
   logic [AW-1:0] cfg_addr = 0;
   logic [7:0] cfg_data = 0;
   logic hit_valid, hit;
   logic [AW-1:0] hit_idx;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int grp_n   = 0;

   logic [7:0] smp [N];
   logic [7:0] ped_t [N];
   logic [7:0] thr_t [N];
   logic [7:0] ped_o [N];
   logic [7:0] thr_o [N];
   logic [N-1:0] rx_vec;
   logic [N-1:0] hist [4];

   strip_cond_chain #(.SAMPLE_W(8), .GROUP_N(N)) u0 (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .hit_valid(hit_valid), .hit(hit), .hit_idx(hit_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (hit_valid) begin
         rx_vec[hit_idx] = hit;
         if (hit_idx == AW'(N-1)) begin
            hist[grp_n % 4] = rx_vec;
            grp_n = grp_n + 1;
         end
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      wait (cyc > 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung (actual cyc=%0d expected <150000)", cyc);
      finish_run();
   end

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] model(input logic [7:0] s [N],
                                          input logic [7:0] p [N],
                                          input logic [7:0] t [N]);
      int sub [N];
      int sum = 0;
      int cmv;
      int c;
      logic [N-1:0] r;
      for (int i = 0; i < N; i++) begin
         sub[i] = (int'(s[i]) > int'(p[i])) ? int'(s[i]) - int'(p[i]) : 0;
         sum += sub[i];
      end
      cmv = sum / N;
      for (int i = 0; i < N; i++) begin
         c = (sub[i] > cmv) ? sub[i] - cmv : 0;
         r[i] = (c > int'(t[i]));
      end
      return r;
   endfunction

   task automatic load_tables();
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         cfg_we = 1; cfg_tbl = 0; cfg_addr = AW'(i); cfg_data = ped_t[i];
         @(negedge clk);
         cfg_tbl = 1; cfg_data = thr_t[i];
      end
      @(negedge clk);
      cfg_we = 0;
      @(negedge clk);
   endtask

   task automatic send_range(input int lo, input int hi, input logic gap);
      for (int i = lo; i <= hi; i++) begin
         @(negedge clk);
         s_valid = 1; s_data = smp[i];
         if (gap) begin
            @(negedge clk);
            s_valid = 0; s_data = 8'hFF;
         end
      end
      @(negedge clk);
      s_valid = 0; s_data = 8'h5A;
   endtask

   task automatic wait_groups(input int target);
      for (int k = 0; k < 400 && grp_n < target; k++) @(negedge clk);
      if (grp_n < target) begin
         n_tests++; n_fail++;
         $display("FAIL R5: group results missing (actual %0d expected %0d)", grp_n, target);
      end
   endtask

   task automatic gen(input int seed, input int pk, input int tk);
      for (int i = 0; i < N; i++) begin
         smp[i]   = 8'((seed * (i + 1) * 29 + i * i * 3 + seed) % 256);
         ped_t[i] = 8'(pk + (i * 5) % 32);
         thr_t[i] = 8'(tk + i % 8);
      end
   endtask

   initial begin
      int base;
      logic [N-1:0] e1;
      logic [N-1:0] e2;
      logic ok;

      repeat (3) @(negedge clk);
      // R1: quiet after reset
      n_tests++;
      if (hit_valid !== 1'b0 || hit !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: reset outputs actual %b%b expected 00", hit_valid, hit);
      end
      rst_n = 1;
      repeat (4) @(negedge clk);
      n_tests++;
      if (hit_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: output before any group actual %b expected 0", hit_valid);
      end

      // R9: tables zero after reset, ramp group gives hits above the mean
      for (int i = 0; i < N; i++) begin
         smp[i] = 8'(i); ped_t[i] = 0; thr_t[i] = 0;
      end
      base = grp_n;
      send_range(0, N-1, 1'b0);
      wait_groups(base + 1);
      check("R9 zero tables", hist[base % 4], model(smp, ped_t, thr_t));

      // R2 R3 R4: vector table
      for (int v = 0; v < 5; v++) begin
         gen(int'(VECS[v].seed), int'(VECS[v].pk), int'(VECS[v].tk));
         load_tables();
         base = grp_n;
         send_range(0, N-1, VECS[v].gap);
         wait_groups(base + 1);
         check(VECS[v].gap ? "R6 R3 vector gapped" : "R3 R4 vector", hist[base % 4],
               model(smp, ped_t, thr_t));
      end

      // R2: baseline above sample clamps to zero
      for (int i = 0; i < N; i++) begin
         ped_t[i] = 8'd200;
         smp[i]   = (i % 4 == 0) ? 8'd250 : 8'd100;
         thr_t[i] = (i % 2 == 0) ? 8'd37 : 8'd38;
      end
      load_tables();
      base = grp_n;
      send_range(0, N-1, 1'b0);
      wait_groups(base + 1);
      e1 = '0;
      for (int i = 0; i < N; i += 4) e1[i] = 1'b1;
      check("R2 clamp", hist[base % 4], e1);

      // R4: equality is not a hit
      for (int i = 0; i < N; i++) begin
         ped_t[i] = 0; smp[i] = 8'd10; thr_t[i] = 8'd200;
      end
      smp[5] = 8'd74; smp[7] = 8'd74; thr_t[5] = 8'd62; thr_t[7] = 8'd61;
      load_tables();
      base = grp_n;
      send_range(0, N-1, 1'b0);
      wait_groups(base + 1);
      e1 = '0; e1[7] = 1'b1;
      check("R4 strict compare", hist[base % 4], e1);

      // R5: exact latency and run length
      gen(55, 5, 20);
      load_tables();
      send_range(0, N-1, 1'b0);
      n_tests++;
      if (hit_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R5: early output actual %b expected 0", hit_valid);
      end
      ok = 1'b1;
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         if (hit_valid !== 1'b1 || hit_idx !== AW'(i)) ok = 1'b0;
      end
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R5: run actual broken expected %0d steps", N);
      end
      @(negedge clk);
      n_tests++;
      if (hit_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R5: run too long actual %b expected 0", hit_valid);
      end

      // R7: writes during a partial group are deferred
      gen(9, 15, 25);
      load_tables();
      for (int i = 0; i < N; i++) begin
         ped_o[i] = ped_t[i]; thr_o[i] = thr_t[i];
      end
      e1 = model(smp, ped_o, thr_o);
      base = grp_n;
      send_range(0, 31, 1'b0);
      for (int i = 0; i < N; i++) begin
         ped_t[i] = 8'd0; thr_t[i] = 8'(i % 3);
      end
      load_tables();
      send_range(32, N-1, 1'b0);
      wait_groups(base + 1);
      check("R7 deferred write", hist[base % 4], e1);
      repeat (3) @(negedge clk);
      base = grp_n;
      send_range(0, N-1, 1'b0);
      wait_groups(base + 1);
      check("R7 applied next group", hist[base % 4], model(smp, ped_t, thr_t));

      // R8: back-to-back groups
      gen(123, 20, 8);
      load_tables();
      e1 = model(smp, ped_t, thr_t);
      for (int i = 0; i < N; i++) ped_o[i] = smp[i];
      base = grp_n;
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         s_valid = 1; s_data = smp[i];
      end
      for (int i = 0; i < N; i++) smp[i] = 8'(255 - int'(ped_o[i]));
      e2 = model(smp, ped_t, thr_t);
      send_range(0, N-1, 1'b0);
      wait_groups(base + 2);
      check("R8 first of pair", hist[base % 4], e1);
      check("R8 second of pair", hist[(base + 1) % 4], e2);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule